// File: doc/BRIEF.md
# Burst Address Generator for a Synchronous SRAM

This block supplies the address that a synchronous burst SRAM presents to its array. An external address is captured when either of two burst-start strobes is asserted. One strobe belongs to the processor side and is honoured only while chip enable is active. The other belongs to the memory controller and loads unconditionally. Both strobes capture the same external address.

After a load, a small beat counter steps the low address bits on each cycle in which the advance input is high. The upper bits keep the captured value. A static order input chooses how the low bits follow the count. In linear order the count is added to the starting low bits, wrapping modulo the group size. In interleaved order the count is XORed into the starting low bits. Bursting is optional, and a new external address may be loaded on every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `mem_addr` is 0, `beat_idx` is 0 and `beat_last` is 0.
- R2: A cycle with `ctl_start`=1 captures `ext_addr` and sets the beat count to 0, whatever the value of `chip_en`. After the next rising edge, `mem_addr` equals the captured `ext_addr`.
- R3: `cpu_start`=1 loads exactly as in R2 when `chip_en`=1. When `chip_en`=0 it is ignored, and the cycle behaves as if the strobe were low.
- R4: In a cycle with `adv`=1 and no accepted load, the beat count increases by one.
- R5: When `order_sel`=1 (linear), the low BEAT_W bits of `mem_addr` are (loaded low bits + beat count) modulo 2^BEAT_W.
- R6: When `order_sel`=0 (interleaved, the default setting), the low BEAT_W bits of `mem_addr` are (loaded low bits XOR beat count).
- R7: When a load is accepted and `adv`=1 in the same cycle, the load takes effect and the beat count becomes 0.
- R8: A cycle with `adv`=0 and no accepted load leaves `mem_addr` and `beat_idx` unchanged.
- R9: The address bits above the low BEAT_W bits keep the loaded value throughout the burst, including when the count wraps.
- R10: `beat_last` is 1 exactly when the beat count is at its maximum, which is 3 for BEAT_W=2.
- R11: An advance from the maximum beat count returns the count to 0, staying within the same address group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable; gates the processor-side strobe |
| cpu_start | input | 1 | Processor-side burst start |
| ctl_start | input | 1 | Controller-side burst start, not gated |
| adv | input | 1 | Advance the beat count |
| order_sel | input | 1 | 1 = linear order, 0 = interleaved order |
| ext_addr | input | ADDR_W | External start address |
| mem_addr | output | ADDR_W | Current internal address |
| beat_idx | output | BEAT_W | Current beat count |
| beat_last | output | 1 | High on the final beat of the group |

## Verification
A burst-start strobe and the advance input can both be active in the same cycle. A start can also arrive just as the count wraps from its last beat. The random stimulus drives the strobes, chip enable and advance independently, so all of these collisions occur many times. Directed sequences also force them at beat 3. In every such cycle the result is judged correct only if the address after the edge is the fresh external address with a beat count of zero. A processor strobe blocked by chip enable must instead leave the advance to act alone.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORDER_INTERLEAVED = 1'b0,
        ORDER_LINEAR      = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
    input  logic chip_en,
    input  logic cpu_start,
    input  logic ctl_start,
    input  logic adv,
    output logic load,
    output logic step
);
    logic cpu_ok;

    always_comb begin
        cpu_ok = cpu_start & chip_en;
        load   = ctl_start | cpu_ok;
        step   = adv & ~load;
    end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_low,
    input  logic [BEAT_W-1:0] count,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] low_out
);
    import burst_addr_pkg::*;

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
            assign ilv_low[gi] = base_low[gi] ^ count[gi];
        end
    endgenerate

    always_comb begin
        lin_low = base_low + count;
        low_out = (burst_order_e'(order_sel) == ORDER_LINEAR) ? lin_low : ilv_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              cpu_start,
    input  logic              ctl_start,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              beat_last
);
    localparam int                UP_W     = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       load, step;
    logic [BEAT_W-1:0] low_bits;

    burst_load_ctl u_load (
        .chip_en   (chip_en),
        .cpu_start (cpu_start),
        .ctl_start (ctl_start),
        .adv       (adv),
        .load      (load),
        .step      (step)
    );

    burst_low_map #(.BEAT_W(BEAT_W)) u_map (
        .base_low  (st_q.base[BEAT_W-1:0]),
        .count     (st_q.beat),
        .order_sel (order_sel),
        .low_out   (low_bits)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = ext_addr;
            st_d.beat = '0;
        end else if (step) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_addr  = {st_q.base[ADDR_W-1 -: UP_W], low_bits};
    assign beat_idx  = st_q.beat;
    assign beat_last = (st_q.beat == BEAT_MAX);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              cpu_start,
    input logic              ctl_start,
    input logic              adv,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BEAT_W-1:0] beat_idx,
    input logic              beat_last
);
    logic acc;
    assign acc = ctl_start | (cpu_start & chip_en);

    assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start |=> (mem_addr == $past(ext_addr)) && (beat_idx == '0));

    assert_cpu_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_start && !chip_en && !ctl_start && !adv) |=> $stable(mem_addr) && $stable(beat_idx));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !acc) |=> beat_idx == BEAT_W'($past(beat_idx) + 1'b1));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && adv) |=> beat_idx == '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !acc) |=> $stable(mem_addr) && $stable(beat_idx));

    assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> mem_addr[ADDR_W-1:BEAT_W] == $past(mem_addr[ADDR_W-1:BEAT_W]));

    assert_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !acc && beat_last) |=> !beat_last && beat_idx == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .cpu_start (cpu_start),
    .ctl_start (ctl_start),
    .adv       (adv),
    .ext_addr  (ext_addr),
    .mem_addr  (mem_addr),
    .beat_idx  (beat_idx),
    .beat_last (beat_last)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    localparam int AW = 20;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0, cpu_start = 1'b0, ctl_start = 1'b0, adv = 1'b0, order_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] beat_idx;
    logic          beat_last;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] m_base = '0;
    logic [BW-1:0] m_beat = '0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cpu_start(cpu_start),
        .ctl_start(ctl_start), .adv(adv), .order_sel(order_sel), .ext_addr(ext_addr),
        .mem_addr(mem_addr), .beat_idx(beat_idx), .beat_last(beat_last)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [BW-1:0] c, logic o);
        logic [BW-1:0] lo;
        lo = o ? BW'(b[BW-1:0] + c) : (b[BW-1:0] ^ c);
        return {b[AW-1:BW], lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [AW-1:0] ea;
        ea = exp_addr(m_base, m_beat, order_sel);
        chk(mem_addr == ea, order_sel ? {req, " R5 R9"} : {req, " R6 R9"}, mem_addr, ea);
        chk(beat_idx == m_beat, {req, " R4 R11"}, AW'(beat_idx), AW'(m_beat));
        chk(beat_last == (m_beat == 2'd3), {req, " R10"}, AW'(beat_last), AW'(m_beat == 2'd3));
    endtask

    task automatic cyc(input logic ce, input logic cs, input logic ks, input logic ad,
                       input logic [AW-1:0] a, input string req);
        @(negedge clk);
        chip_en = ce; cpu_start = cs; ctl_start = ks; adv = ad; ext_addr = a;
        @(posedge clk);
        if (ks || (cs && ce)) begin
            m_base = a; m_beat = '0;
        end else if (ad) begin
            m_beat = m_beat + 1'b1;
        end
        #2;
        check_all(req);
    endtask

    initial begin : watchdog
        #1500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        chk(mem_addr == '0 && beat_idx == '0 && !beat_last, "R1 in reset", mem_addr, '0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        chk(mem_addr == '0 && beat_idx == '0 && !beat_last, "R1 after release", mem_addr, '0);

        order_sel = 1'b1;
        cyc(0, 0, 1, 0, 20'hABCD2, "R2 ctl load chip_en=0");
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 20'h0, "R4 linear advance wrap R11");
        cyc(0, 1, 0, 0, 20'h12345, "R3 blocked cpu hold R8");
        cyc(0, 1, 0, 1, 20'h55555, "R3 blocked cpu acts as advance");
        cyc(1, 1, 0, 0, 20'h77771, "R3 cpu load");
        order_sel = 1'b0;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 20'h0, "R6 interleaved");
        cyc(1, 1, 0, 1, 20'h0F0F3, "R7 load at beat 3 with adv");
        cyc(0, 0, 1, 1, 20'hFFFFF, "R7 ctl load with adv");
        cyc(1, 0, 0, 0, 20'h0, "R8 hold");

        for (int i = 0; i < 3000; i++) begin
            if ((i % 500) == 0) order_sel = $urandom_range(0, 1);
            cyc($urandom_range(0, 1), ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                $urandom_range(0, 1), AW'($urandom), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule